// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Queue

This block is a byte-wide code buffer placed between an instruction cache and a decoder whose instructions vary in length. On one side it asks the cache for aligned 16-byte code chunks at a running fetch address and stores each returned chunk in a single cycle. On the other side it shows the decoder the oldest 16 buffered bytes together with how many of them are valid. The decoder then reports how many bytes the instruction it just decoded occupied. Those bytes are dropped from the head of the buffer.

A redirect from branch prediction empties the buffer at once and loads the fetch address with the new target. A chunk that is already in flight when the redirect arrives is thrown away when it returns. If the target does not sit on a 16-byte boundary, the first chunk fetched after the redirect is written without its leading bytes, so the head of the buffer is exactly the target byte.

Fetch control is a three-state machine. ST_ISSUE offers a request whenever at least one chunk of space is free. ST_WAIT waits for the requested chunk. ST_DROP waits for a stale chunk that a redirect has made useless. The transitions are:
- ISSUE to WAIT when a request is accepted.
- ISSUE to DROP when a request is accepted in the same cycle as a redirect.
- WAIT to ISSUE when the chunk arrives, whether or not a redirect comes with it.
- WAIT to DROP when a redirect arrives with no chunk.
- DROP to ISSUE when the stale chunk arrives.
- Every other case keeps the current state.

Top module: `ifq_prefetch`

## Requirements
- R1: After reset the window count is 0, a fetch request is offered, and the request address is the reset address (0).
- R2: An accepted chunk places all 16 bytes in the buffer in a single cycle. Byte lane k of the fill data (bits 8k+7:8k) is the code byte at chunk address + k.
- R3: The buffer never holds more than 48 bytes. A request is offered only while at least 16 bytes are free and no chunk is outstanding.
- R4: The window shows the oldest buffered bytes in order, with lane k holding the k-th oldest byte. The window count equals the smaller of the occupancy and 16.
- R5: A consume of n bytes, where 1 ≤ n ≤ window count, removes exactly the n oldest bytes. The head position wraps modulo 48.
- R6: When a fill and a consume happen in the same cycle, the occupancy afterwards is the old occupancy plus the filled bytes minus the consumed bytes.
- R7: In the cycle after a redirect, the window count is 0 and the request address is the target with its low 4 bits cleared. A consume in the redirect cycle has no effect.
- R8: A chunk that was requested before a redirect, or accepted in the same cycle as one, is discarded when it returns. No new request is offered until that chunk has returned.
- R9: After a redirect to target t, the first accepted chunk adds only 16 − t[3:0] bytes, and the head byte is the byte at t.
- R10: At most one chunk is outstanding. Each accepted request advances the fetch address by 16, and every request address is 16-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Flush the buffer and restart fetch at the target |
| redirect_addr | input | ADDR_W | Redirect target byte address |
| fetch_req_valid | output | 1 | Chunk request offered to the cache |
| fetch_req_ready | input | 1 | Cache accepts the request |
| fetch_req_addr | output | ADDR_W | Aligned chunk address being requested |
| fill_valid | input | 1 | Requested chunk returns this cycle |
| fill_data | input | CHUNK*8 | Chunk bytes, lane k at bits 8k+7:8k |
| win_data | output | WIN*8 | Head bytes, oldest byte in lane 0 |
| win_count | output | CNT_W | Number of valid window bytes |
| consume_valid | input | 1 | Decoder drops bytes this cycle |
| consume_len | input | CNT_W | Number of bytes dropped, from 1 to win_count |

## Verification
Several events can coincide in one cycle, and the bench drives them together on purpose. The main pairings are a chunk arriving while the decoder consumes bytes, and a redirect landing on an accepted request or on a returning chunk. Directed steps set up each pairing once: a redirect together with an accepted request, a redirect together with a chunk return in the drop state, and a full-width consume during a fill. A long random phase then overlaps them freely. In every cycle the bench compares the window bytes, the window count, the request valid and the request address against its own model. That model tracks the head address, occupancy, pending or stale chunk and skip offset, and the expected bytes come from a fixed address-to-byte pattern.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DROP  = 2'd2
    } fetch_state_e;

    function automatic int wrap_idx(input int v, input int depth);
        return (v >= depth) ? v - depth : v;
    endfunction

endpackage

// File: rtl/ifq_fetch_ctrl.sv
module ifq_fetch_ctrl
    import ifq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CHUNK      = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int OFS_W     = $clog2(CHUNK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_valid,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              room_ok,
    input  logic              req_ready,
    input  logic              fill_valid,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              fill_accept,
    output logic [OFS_W-1:0]  skip
);

    fetch_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [OFS_W-1:0]  skip_q;
    logic              fire;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ISSUE: begin
                if (fire)
                    state_d = redirect_valid ? ST_DROP : ST_WAIT;
            end
            ST_WAIT: begin
                if (fill_valid)
                    state_d = ST_ISSUE;
                else if (redirect_valid)
                    state_d = ST_DROP;
            end
            ST_DROP: begin
                if (fill_valid)
                    state_d = ST_ISSUE;
            end
            default: state_d = ST_ISSUE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ISSUE;
            addr_q  <= {RESET_ADDR[ADDR_W-1:OFS_W], OFS_W'(0)};
            skip_q  <= RESET_ADDR[OFS_W-1:0];
        end else begin
            state_q <= state_d;
            if (redirect_valid) begin
                addr_q <= {redirect_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
                skip_q <= redirect_addr[OFS_W-1:0];
            end else begin
                if (fire)
                    addr_q <= addr_q + ADDR_W'(CHUNK);
                if (fill_accept)
                    skip_q <= '0;
            end
        end
    end

    always_comb begin
        req_valid   = (state_q == ST_ISSUE) && room_ok;
        fire        = req_valid && req_ready;
        req_addr    = addr_q;
        fill_accept = (state_q == ST_WAIT) && fill_valid && !redirect_valid;
        skip        = skip_q;
    end

endmodule

// File: rtl/ifq_byte_store.sv
module ifq_byte_store
    import ifq_pkg::*;
#(
    parameter int CHUNK  = 16,
    parameter int DEPTH  = 48,
    parameter int WIN    = 16,
    localparam int OFS_W = $clog2(CHUNK),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_base,
    input  logic [OFS_W-1:0]   wr_skip,
    input  logic [CHUNK*8-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_head,
    output logic [WIN*8-1:0]   win_data
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_idx [CHUNK];
    logic             lane_we [CHUNK];

    always_comb begin
        for (int i = 0; i < CHUNK; i++) begin
            lane_we[i] = wr_en && (i >= int'(wr_skip));
            wr_idx[i]  = PTR_W'(wrap_idx(int'(wr_base) + i - int'(wr_skip) + DEPTH, DEPTH) % DEPTH);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < CHUNK; i++) begin
            if (lane_we[i])
                mem[wr_idx[i]] <= wr_data[i*8 +: 8];
        end
    end

    always_comb begin
        for (int i = 0; i < WIN; i++)
            win_data[i*8 +: 8] = mem[PTR_W'(wrap_idx(int'(rd_head) + i, DEPTH))];
    end

endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch
    import ifq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CHUNK      = 16,
    parameter int DEPTH      = 48,
    parameter int WIN        = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W     = $clog2(WIN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect_valid,
    input  logic [ADDR_W-1:0]  redirect_addr,
    output logic               fetch_req_valid,
    input  logic               fetch_req_ready,
    output logic [ADDR_W-1:0]  fetch_req_addr,
    input  logic               fill_valid,
    input  logic [CHUNK*8-1:0] fill_data,
    output logic [WIN*8-1:0]   win_data,
    output logic [CNT_W-1:0]   win_count,
    input  logic               consume_valid,
    input  logic [CNT_W-1:0]   consume_len
);

    localparam int OFS_W = $clog2(CHUNK);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ;
    logic             room_ok, fill_accept;
    logic [OFS_W-1:0] skip;
    int               add_n, sub_n;

    assign room_ok = int'(occ) <= DEPTH - CHUNK;

    ifq_fetch_ctrl #(
        .ADDR_W(ADDR_W), .CHUNK(CHUNK), .RESET_ADDR(RESET_ADDR)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .room_ok(room_ok), .req_ready(fetch_req_ready), .fill_valid(fill_valid),
        .req_valid(fetch_req_valid), .req_addr(fetch_req_addr),
        .fill_accept(fill_accept), .skip(skip)
    );

    ifq_byte_store #(
        .CHUNK(CHUNK), .DEPTH(DEPTH), .WIN(WIN)
    ) store_i (
        .clk(clk), .wr_en(fill_accept), .wr_base(tail_q), .wr_skip(skip),
        .wr_data(fill_data), .rd_head(head_q), .win_data(win_data)
    );

    always_comb begin
        add_n = fill_accept ? CHUNK - int'(skip) : 0;
        sub_n = consume_valid ? int'(consume_len) : 0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || redirect_valid) begin
            head_q <= '0;
            tail_q <= '0;
            occ    <= '0;
        end else begin
            head_q <= PTR_W'(wrap_idx(int'(head_q) + sub_n, DEPTH));
            tail_q <= PTR_W'(wrap_idx(int'(tail_q) + add_n, DEPTH));
            occ    <= OCC_W'(int'(occ) + add_n - sub_n);
        end
    end

    assign win_count = (int'(occ) >= WIN) ? CNT_W'(WIN) : CNT_W'(occ);

endmodule

// File: rtl/ifq_prefetch_chk.sv
module ifq_prefetch_chk #(
    parameter int ADDR_W = 32,
    parameter int CHUNK  = 16,
    parameter int DEPTH  = 48,
    parameter int CNT_W  = 5,
    parameter int OCC_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_addr,
    input logic              fetch_req_valid,
    input logic              fetch_req_ready,
    input logic [ADDR_W-1:0] fetch_req_addr,
    input logic              consume_valid,
    input logic [CNT_W-1:0]  consume_len,
    input logic [CNT_W-1:0]  win_count,
    input logic [OCC_W-1:0]  occ
);

    localparam int OFS_W = $clog2(CHUNK);

    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH); // R3

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> win_count == '0); // R7

    AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> fetch_req_addr ==
            {$past(redirect_addr[ADDR_W-1:OFS_W]), OFS_W'(0)}); // R7

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid |-> fetch_req_addr[OFS_W-1:0] == '0); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_valid && fetch_req_ready && !redirect_valid) |=>
            fetch_req_addr == $past(fetch_req_addr) + ADDR_W'(CHUNK)); // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_valid && fetch_req_ready) |=> !fetch_req_valid); // R10

    AST_CONSUME_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        consume_valid |-> (consume_len != '0 && consume_len <= win_count)); // R5

endmodule

bind ifq_prefetch ifq_prefetch_chk #(
    .ADDR_W(ADDR_W), .CHUNK(CHUNK), .DEPTH(DEPTH),
    .CNT_W(CNT_W), .OCC_W($clog2(DEPTH + 1))
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr),
    .consume_valid(consume_valid), .consume_len(consume_len),
    .win_count(win_count), .occ(occ)
);

// File: tb/ifq_prefetch_tb.sv
module ifq_prefetch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            redirect_valid = 1'b0;
    logic [AW-1:0]   redirect_addr = '0;
    logic            fetch_req_valid;
    logic            fetch_req_ready = 1'b0;
    logic [AW-1:0]   fetch_req_addr;
    logic            fill_valid = 1'b0;
    logic [127:0]    fill_data = '0;
    logic [127:0]    win_data;
    logic [4:0]      win_count;
    logic            consume_valid = 1'b0;
    logic [4:0]      consume_len = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int          m_cnt = 0;
    int          m_skip = 0;
    logic [31:0] m_head = '0;
    logic [31:0] m_fetch = '0;
    logic [31:0] m_filladdr = '0;
    bit          m_pend = 0;
    bit          m_stale = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifq_prefetch dut_i (
        .clk(clk), .rst_n(rst_n),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_addr(fetch_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .win_data(win_data), .win_count(win_count),
        .consume_valid(consume_valid), .consume_len(consume_len)
    );

    function automatic logic [7:0] code_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic int min16(input int v);
        return (v > 16) ? 16 : v;
    endfunction

    function automatic bit exp_req();
        return !m_pend && !m_stale && (48 - m_cnt >= 16);
    endfunction

    task automatic chk(input longint act, input longint expv, input string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_outputs();
        chk(win_count, min16(m_cnt), "R4 window count");
        for (int i = 0; i < min16(m_cnt); i++)
            chk(win_data[i*8 +: 8], code_byte(m_head + 32'(i)), "R4 R5 window byte");
        chk(fetch_req_valid, exp_req(), "R3 R10 request valid");
        if (exp_req())
            chk(fetch_req_addr, m_fetch, "R10 request address");
    endtask

    task automatic step(input bit rv, input logic [31:0] rt, input bit rdy,
                        input bit fv, input bit cv, input int cl);
        bit fire;
        bit outst;
        redirect_valid  = rv;
        redirect_addr   = rt;
        fetch_req_ready = rdy;
        fill_valid      = fv;
        for (int k = 0; k < 16; k++)
            fill_data[k*8 +: 8] = code_byte(m_filladdr + 32'(k));
        consume_valid   = cv;
        consume_len     = 5'(cl);
        fire  = exp_req() && rdy;
        outst = m_pend || m_stale;
        @(posedge clk);
        if (fire)
            m_filladdr = m_fetch;
        if (rv) begin
            m_cnt   = 0;
            m_head  = rt;
            m_fetch = {rt[31:4], 4'h0};
            m_skip  = int'(rt[3:0]);
            m_stale = fire || (outst && !fv);
            m_pend  = 0;
        end else begin
            int add_n = 0;
            if (fv && m_pend) begin
                add_n  = 16 - m_skip;
                m_skip = 0;
                m_pend = 0;
            end else if (fv && m_stale) begin
                m_stale = 0;
            end
            if (cv) begin
                m_cnt  = m_cnt - cl;
                m_head = m_head + 32'(cl);
            end
            m_cnt = m_cnt + add_n;
            if (fire) begin
                m_pend  = 1;
                m_fetch = m_fetch + 32'd16;
            end
        end
        @(negedge clk);
        redirect_valid = 0;
        fetch_req_ready = 0;
        fill_valid = 0;
        consume_valid = 0;
        check_outputs();
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(win_count, 0, "R1 reset count");
        chk(fetch_req_valid, 1, "R1 reset request valid");
        chk(fetch_req_addr, 0, "R1 reset address");

        step(0, 0, 1, 0, 0, 0);
        chk(fetch_req_valid, 0, "R10 no second request");
        step(0, 0, 0, 1, 0, 0);
        chk(win_count, 16, "R2 full chunk in one cycle");
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk(fetch_req_valid, 0, "R3 no request when full");
        step(0, 0, 0, 0, 1, 5);
        chk(fetch_req_valid, 0, "R3 under 16 bytes free");
        step(0, 0, 0, 0, 1, 16);
        step(0, 0, 1, 0, 1, 7);
        step(0, 0, 0, 1, 1, 16);
        chk(win_count, 16, "R6 fill with consume");
        step(0, 0, 0, 0, 1, 16);
        step(0, 0, 0, 0, 1, 4);
        chk(win_count, 0, "R6 occupancy after drain");

        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(1, 32'h2005, 0, 0, 1, 3);
        chk(win_count, 0, "R7 flushed");
        chk(fetch_req_addr, 32'h2000, "R7 aligned target");
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        chk(win_count, 11, "R9 skipped leading bytes");
        chk(win_data[7:0], code_byte(32'h2005), "R9 head is target byte");

        step(1, 32'h300F, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(1, 32'h4001, 0, 0, 0, 0);
        chk(fetch_req_valid, 0, "R8 wait for stale chunk");
        step(0, 0, 0, 1, 0, 0);
        chk(win_count, 0, "R8 stale chunk discarded");
        chk(fetch_req_addr, 32'h4000, "R8 restart address");
        step(1, 32'h5008, 1, 0, 0, 0);
        chk(fetch_req_valid, 0, "R8 redirect with accepted request");
        step(1, 32'h6000, 0, 1, 0, 0);
        chk(fetch_req_valid, 1, "R8 stale return with redirect");
        chk(fetch_req_addr, 32'h6000, "R8 new target");

        for (int n = 0; n < 4000; n++) begin
            bit rv = ($urandom % 40) == 0;
            bit fv = (m_pend || m_stale) && ($urandom % 2 == 0);
            bit cv = (m_cnt > 0) && ($urandom % 4 != 0);
            int cl = cv ? 1 + int'($urandom % min16(m_cnt)) : 0;
            step(rv, $urandom, ($urandom % 3) != 0, fv, cv, cl);
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule